// File: doc/BRIEF.md
# Call and Return Stack Controller

This block carries out the stack half of long subroutine calls and returns for an 8-bit microcontroller core. It owns an 8-bit stack pointer, a byte-wide internal stack memory and the 16-bit program counter value that results from a call or a return. A call request carries the address of the 3-byte call instruction and the 16-bit destination. The block derives the return address, stores it on the stack as two bytes, and then loads the program counter with the destination.

A return request reads the two saved bytes back in reverse order and moves the stack pointer down. It then places the restored address in the program counter. Each byte transfer takes one clock. A busy output stays high while a two-byte sequence is in progress, and new requests are not accepted during that time. A parameter sets the highest stack pointer value a call may reach, which bounds the nesting depth. A call that would go past this limit is refused, and a sticky overflow flag records the refusal.

Top module: `call_ret_stack`

## Requirements
- R1: After reset, `sp_out` is 0x07, `pc_out` is 0x0000, and `busy` and `overflow` are both low.
- R2: An accepted call stores the return address `call_pc + 3` (16-bit, wrapping). The low byte is written at SP+1 and the high byte at SP+2. Each write is preceded by a one-step increment of SP, so SP ends 2 higher.
- R3: Two clocks after the accepting edge, the call completes: `pc_out` equals the latched `call_target` and `busy` falls.
- R4: An accepted return reads the byte at SP as the high byte and then decrements SP. It then reads the byte at the new SP as the low byte and decrements again. After this, `pc_out` holds {high, low} and SP is 2 lower.
- R5: `busy` is high for exactly the two clock cycles after the accepting edge of a call or return, and SP moves by one in each of those cycles.
- R6: A call is accepted only when SP+2 does not exceed `SP_LIMIT`, and reaching exactly `SP_LIMIT` is allowed. Otherwise the call is refused: `overflow` goes high on the request edge, `busy` stays low, and SP, PC and the stack contents are unchanged.
- R7: Once `overflow` is high it stays high until reset. Later returns still operate normally.
- R8: Requests that arrive while `busy` is high are ignored, including any change to `call_pc` or `call_target`.
- R9: When `call_req` and `ret_req` are both high in an idle cycle, the call is performed and the return is dropped.
- R10: Nested calls and returns behave last-in first-out: each return restores the return address of the most recent call that has not yet returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Request a long call (sampled when idle) |
| ret_req | input | 1 | Request a return (sampled when idle) |
| call_pc | input | 16 | Address of the 3-byte call instruction |
| call_target | input | 16 | Destination address of the call |
| pc_out | output | 16 | Program counter produced by the last call or return |
| sp_out | output | SP_W (8) | Current stack pointer |
| busy | output | 1 | High while a two-byte push or pop sequence runs |
| overflow | output | 1 | Sticky flag: a call was refused at the stack limit |

## Verification
On every cycle, the embedded assertions check the following. SP moves by exactly one step in the direction of each push or pop, and never both at once. A push phase is always followed by its second byte. PC takes the latched destination when a call finishes. SP never rises above the limit. The overflow flag never clears without reset, and a refused call leaves the sequencer idle.

The byte values and their order on the stack can only be shown by the bench's scenarios. These are observed at the ports through later returns. The scenarios also cover the return address carry into the high byte, LIFO restoration across nesting, the ignoring of requests while busy, call priority over a simultaneous return, and acceptance exactly at the limit.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int ADDR_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int CALL_BYTES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_HI,
        ST_POP_LO
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } addr_bytes_t;

    function automatic addr_bytes_t return_addr_of(input logic [ADDR_W-1:0] call_at);
        addr_bytes_t r;
        r = addr_bytes_t'(call_at + ADDR_W'(CALL_BYTES));
        return r;
    endfunction

endpackage

// File: rtl/csc_stack_ram.sv
module csc_stack_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/csc_sp_unit.sv
module csc_sp_unit #(
    parameter int          SP_W     = 8,
    parameter logic [7:0]  SP_RESET = 8'h07,
    parameter logic [7:0]  SP_LIMIT = 8'h7F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    input  logic            dec,
    input  logic            ovf_set,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_plus1,
    output logic            room_two,
    output logic            overflow
);
    localparam logic [SP_W:0] LIMIT_EXT = (SP_W+1)'(SP_LIMIT);
    localparam logic [SP_W:0] NEED      = (SP_W+1)'(2);

    logic [SP_W-1:0] sp_q;
    logic            ovf_q;

    assign sp       = sp_q;
    assign sp_plus1 = sp_q + SP_W'(1);
    assign room_two = ({1'b0, sp_q} + NEED) <= LIMIT_EXT;
    assign overflow = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= SP_W'(SP_RESET);
            ovf_q <= 1'b0;
        end else begin
            if (inc) begin
                sp_q <= sp_plus1;
            end else if (dec) begin
                sp_q <= sp_q - SP_W'(1);
            end
            if (ovf_set) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // R2: pre-increment moves SP up by one per pushed byte
    a_r2_sp_step_up: assert property (@(posedge clk) disable iff (rst)
        inc |=> sp_q == $past(sp_q) + SP_W'(1));

    // R4: each popped byte lowers SP by one
    a_r4_sp_step_down: assert property (@(posedge clk) disable iff (rst)
        dec |=> sp_q == $past(sp_q) - SP_W'(1));

    // R5: push and pop never overlap
    a_r5_no_dual_step: assert property (@(posedge clk) disable iff (rst)
        !(inc && dec));

    // R6: the limit is never crossed by pushes
    a_r6_sp_within_limit: assert property (@(posedge clk) disable iff (rst)
        $past(inc) |-> ({1'b0, sp_q} <= LIMIT_EXT));

    // R7: overflow is sticky
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

endmodule

// File: rtl/csc_sequencer.sv
module csc_sequencer
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic [ADDR_W-1:0] call_target,
    input  logic              room_two,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              busy,
    output logic              sp_inc,
    output logic              sp_dec,
    output logic              mem_we,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              ovf_set,
    output logic [ADDR_W-1:0] pc
);
    seq_state_e        state_q, state_d;
    addr_bytes_t       ret_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [BYTE_W-1:0] hi_q;
    logic [ADDR_W-1:0] pc_q;
    logic              accept_call;
    logic              accept_ret;

    assign accept_call = (state_q == ST_IDLE) && call_req && room_two;
    assign accept_ret  = (state_q == ST_IDLE) && !call_req && ret_req;

    always_comb begin
        state_d = state_q;
        sp_inc  = 1'b0;
        sp_dec  = 1'b0;
        mem_we  = 1'b0;
        wr_byte = '0;
        ovf_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (call_req) begin
                    if (room_two) state_d = ST_PUSH_LO;
                    else          ovf_set = 1'b1;
                end else if (ret_req) begin
                    state_d = ST_POP_HI;
                end
            end
            ST_PUSH_LO: begin
                sp_inc  = 1'b1;
                mem_we  = 1'b1;
                wr_byte = ret_q.lo;
                state_d = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                sp_inc  = 1'b1;
                mem_we  = 1'b1;
                wr_byte = ret_q.hi;
                state_d = ST_IDLE;
            end
            ST_POP_HI: begin
                sp_dec  = 1'b1;
                state_d = ST_POP_LO;
            end
            ST_POP_LO: begin
                sp_dec  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ret_q   <= '0;
            tgt_q   <= '0;
            hi_q    <= '0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept_call) begin
                ret_q <= return_addr_of(call_pc);
                tgt_q <= call_target;
            end
            if (state_q == ST_PUSH_HI) begin
                pc_q <= tgt_q;
            end
            if (state_q == ST_POP_HI) begin
                hi_q <= rd_byte;
            end
            if (state_q == ST_POP_LO) begin
                pc_q <= {hi_q, rd_byte};
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign pc   = pc_q;

    // R5: the low byte push is always followed by the high byte push
    a_r5_push_pair: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_PUSH_LO |=> state_q == ST_PUSH_HI);

    // R5: the first pop is always followed by the second
    a_r5_pop_pair: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_POP_HI |=> state_q == ST_POP_LO);

    // R3: a finishing call leaves PC at the latched destination
    a_r3_pc_target: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_PUSH_HI |=> pc_q == $past(tgt_q));

    // R6: a refused call keeps the sequencer idle
    a_r6_refused_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && call_req && !room_two) |=> state_q == ST_IDLE);

    // R9: a call request wins over a simultaneous return
    a_r9_call_first: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && call_req && ret_req && room_two) |=> state_q == ST_PUSH_LO);

    // R8: PC is held while a sequence is still mid-way
    a_r8_pc_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PUSH_LO || state_q == ST_POP_HI) |=> $stable(pc_q));

endmodule

// File: rtl/call_ret_stack.sv
module call_ret_stack
    import csc_pkg::*;
#(
    parameter int         SP_W     = 8,
    parameter logic [7:0] SP_RESET = 8'h07,
    parameter logic [7:0] SP_LIMIT = 8'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic [ADDR_W-1:0] call_target,
    output logic [ADDR_W-1:0] pc_out,
    output logic [SP_W-1:0]   sp_out,
    output logic              busy,
    output logic              overflow
);
    logic              sp_inc;
    logic              sp_dec;
    logic              ovf_set;
    logic              room_two;
    logic              mem_we;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;
    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   sp_plus1;

    csc_sp_unit #(
        .SP_W     (SP_W),
        .SP_RESET (SP_RESET),
        .SP_LIMIT (SP_LIMIT)
    ) sp_i (
        .clk      (clk),
        .rst      (rst),
        .inc      (sp_inc),
        .dec      (sp_dec),
        .ovf_set  (ovf_set),
        .sp       (sp),
        .sp_plus1 (sp_plus1),
        .room_two (room_two),
        .overflow (overflow)
    );

    csc_sequencer seq_i (
        .clk         (clk),
        .rst         (rst),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .call_pc     (call_pc),
        .call_target (call_target),
        .room_two    (room_two),
        .rd_byte     (rd_byte),
        .busy        (busy),
        .sp_inc      (sp_inc),
        .sp_dec      (sp_dec),
        .mem_we      (mem_we),
        .wr_byte     (wr_byte),
        .ovf_set     (ovf_set),
        .pc          (pc_out)
    );

    csc_stack_ram #(
        .AW (SP_W),
        .DW (BYTE_W)
    ) ram_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (sp_plus1),
        .wdata (wr_byte),
        .raddr (sp),
        .rdata (rd_byte)
    );

    assign sp_out = sp;

    // R1: reset state visible one cycle after reset is applied
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (sp_out == SP_W'(SP_RESET) && pc_out == '0 && !busy && !overflow));

endmodule

// File: tb/call_ret_stack_tb_top.sv
module call_ret_stack_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] LIM        = 8'h0D;

    logic        clk = 1'b0;
    logic        rst;
    logic        call_req;
    logic        ret_req;
    logic [15:0] call_pc;
    logic [15:0] call_target;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic        busy;
    logic        overflow;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    call_ret_stack #(.SP_W(8), .SP_RESET(8'h07), .SP_LIMIT(LIM)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .call_pc     (call_pc),
        .call_target (call_target),
        .pc_out      (pc_out),
        .sp_out      (sp_out),
        .busy        (busy),
        .overflow    (overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; call_req = 1'b0; ret_req = 1'b0;
        call_pc = '0; call_target = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    // accepted call: busy two cycles, then PC at target and SP up by 2
    task automatic do_call(input logic [15:0] at, input logic [15:0] tgt,
                           input logic [7:0] sp_exp, input string req);
        call_pc = at; call_target = tgt; call_req = 1'b1;
        @(negedge clk);
        call_req = 1'b0;
        chk({req, " R5 busy cycle1"}, 32'(busy), 32'd1);
        @(negedge clk);
        chk({req, " R5 busy cycle2"}, 32'(busy), 32'd1);
        @(negedge clk);
        chk({req, " R5 busy done"}, 32'(busy), 32'd0);
        chk({req, " R3 pc target"}, 32'(pc_out), 32'(tgt));
        chk({req, " R2 sp after call"}, 32'(sp_out), 32'(sp_exp));
    endtask

    task automatic do_ret(input logic [15:0] pc_exp, input logic [7:0] sp_exp, input string req);
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk({req, " R5 ret busy"}, 32'(busy), 32'd1);
        @(negedge clk);
        @(negedge clk);
        chk({req, " R4 pc restored"}, 32'(pc_out), 32'(pc_exp));
        chk({req, " R4 sp after ret"}, 32'(sp_out), 32'(sp_exp));
        chk({req, " R5 ret idle"}, 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 sp", 32'(sp_out), 32'h07);
        chk("R1 pc", 32'(pc_out), 32'h0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 overflow", 32'(overflow), 32'd0);
    endtask

    task automatic t_nested();
        do_call(16'h1234, 16'h4000, 8'h09, "R2");
        do_call(16'h40FE, 16'h8000, 8'h0B, "R10 carry");
        do_ret(16'h4101, 8'h09, "R10 inner");
        do_ret(16'h1237, 8'h07, "R10 outer");
    endtask

    task automatic t_busy_ignore();
        call_pc = 16'h2000; call_target = 16'h3000; call_req = 1'b1;
        @(negedge clk);
        call_pc = 16'h5555; call_target = 16'h6666; ret_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        chk("R8 pc", 32'(pc_out), 32'h3000);
        chk("R8 sp", 32'(sp_out), 32'h09);
        @(negedge clk);
        chk("R8 no extra op", 32'(busy), 32'd0);
        do_ret(16'h2003, 8'h07, "R8");
    endtask

    task automatic t_simultaneous();
        call_pc = 16'h0100; call_target = 16'h0200; call_req = 1'b1; ret_req = 1'b1;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 pc", 32'(pc_out), 32'h0200);
        chk("R9 sp", 32'(sp_out), 32'h09);
        do_ret(16'h0103, 8'h07, "R9");
    endtask

    task automatic t_overflow();
        do_call(16'hA000, 16'hB000, 8'h09, "R6 fill1");
        do_call(16'hB010, 16'hC000, 8'h0B, "R6 fill2");
        do_call(16'hC0FF, 16'hD000, 8'h0D, "R6 at limit");
        call_pc = 16'hD000; call_target = 16'hE000; call_req = 1'b1;
        @(negedge clk);
        call_req = 1'b0;
        chk("R6 overflow set", 32'(overflow), 32'd1);
        chk("R6 busy low", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R6 sp held", 32'(sp_out), 32'h0D);
        chk("R6 pc held", 32'(pc_out), 32'hD000);
        do_ret(16'hC102, 8'h0B, "R6 stack intact");
        chk("R7 still set", 32'(overflow), 32'd1);
        do_ret(16'hB013, 8'h09, "R7");
        chk("R7 sticky", 32'(overflow), 32'd1);
        do_reset();
        chk("R7 cleared by reset", 32'(overflow), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_nested();
        t_busy_ignore();
        t_simultaneous();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule